// File: doc/BRIEF.md
# Two-Output Interrupt Router

This block collects 32 level-sensitive interrupt request lines and forwards them to a processor over two lines. One is a normal request line and the other is a fast request line. Each source has an enable bit that gates it. Each source also has a routing bit that chooses which of the two lines it drives. Software reaches the block through a simple word-indexed register port. Through that port it can read three status views: the unmasked inputs, the sources headed for the normal line and the sources headed for the fast line. It can also read and write the routing bits. The enable mask has no plain write port: software changes it only by writing ones to a set port or a clear port.

A protection bit closes the register port to non-privileged writes. Once set, only privileged writes change anything. Reads are never restricted. Sources are level-sensitive, so the block holds no pending state. A status bit stays up exactly as long as its input is high and unmasked.

Top module: `intc_route`

## Requirements
- R1: After reset the enable mask, the routing bits and the protection bit are all zero, and `irq_o` and `fiq_o` are low.
- R2: Reading index 2 returns `src_i` as it is in that cycle, unaffected by enable or routing bits.
- R3: A permitted write to index 4 sets every enable bit whose data bit is 1 and leaves the bits written as 0 unchanged. Reading index 4 returns the current enable mask.
- R4: A permitted write to index 5 clears every enable bit whose data bit is 1 and leaves the others unchanged. Reading index 5 always returns zero.
- R5: Reading index 0 returns `src_i & enable & ~route`. Reading index 1 returns `src_i & enable & route`.
- R6: Index 3 holds the routing bits and is readable and writable. A routing bit of 0 sends the source to the normal line, and 1 sends it to the fast line.
- R7: At each clock edge, `irq_o` takes the OR of the index-0 view and `fiq_o` takes the OR of the index-1 view. Both use the values present before that edge.
- R8: Index 8 bit 0 is the protection bit. While it is 1, a write with `bus_priv` low changes no register. A write with `bus_priv` high still takes effect, and reads are unaffected.
- R9: A status bit falls in the same cycle its input falls, and its output line follows one edge later. Nothing is latched.
- R10: Writes to unmapped indices (6, 7, 9 to 15) change no register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt request lines |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_idx | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx`, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The assertions check several rules on every cycle. They track the set and clear effects of a write on the mask and the freezing of all registers under protection. They check both masked status views against the inputs, and they check that each output line follows the OR of its view one edge later. Other behaviour only the scenarios can show. These cases are the reset values, that zero bits in a set or clear write leave the mask alone, the exact values read back from the select and protection registers, the handling of unmapped indices, and that an output falls after its source is withdrawn.

// File: rtl/intc_route_pkg.sv
package intc_route_pkg;
    parameter int NSRC  = 32;
    parameter int IDX_W = 4;

    localparam logic [IDX_W-1:0] IX_IRQ_ST = 4'd0;
    localparam logic [IDX_W-1:0] IX_FIQ_ST = 4'd1;
    localparam logic [IDX_W-1:0] IX_RAW    = 4'd2;
    localparam logic [IDX_W-1:0] IX_ROUTE  = 4'd3;
    localparam logic [IDX_W-1:0] IX_EN_SET = 4'd4;
    localparam logic [IDX_W-1:0] IX_EN_CLR = 4'd5;
    localparam logic [IDX_W-1:0] IX_PROT   = 4'd8;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] route;
        logic            prot;
    } cfg_t;

    typedef struct packed {
        logic irq;
        logic fiq;
    } lines_t;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_route_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic                  bus_priv,
    input  logic [IDX_W-1:0]      bus_idx,
    input  logic [NSRC-1:0]       bus_wdata,
    output cfg_t                  cfg_o
);
    cfg_t cfg_d, cfg_q;
    logic wr_ok;

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = bus_en && bus_we && (bus_priv || !cfg_q.prot);
        if (wr_ok) begin
            unique case (bus_idx)
                IX_EN_SET: cfg_d.en    = cfg_q.en | bus_wdata;
                IX_EN_CLR: cfg_d.en    = cfg_q.en & ~bus_wdata;
                IX_ROUTE:  cfg_d.route = bus_wdata;
                IX_PROT:   cfg_d.prot  = bus_wdata[0];
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/intc_steer.sv
module intc_steer
    import intc_route_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] route_i,
    output logic [NSRC-1:0] irq_stat_o,
    output logic [NSRC-1:0] fiq_stat_o,
    output logic            irq_o,
    output logic            fiq_o
);
    lines_t lines_d, lines_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign irq_stat_o[s] = src_i[s] & en_i[s] & ~route_i[s];
        assign fiq_stat_o[s] = src_i[s] & en_i[s] &  route_i[s];
    end

    always_comb begin
        lines_d     = lines_q;
        lines_d.irq = |irq_stat_o;
        lines_d.fiq = |fiq_stat_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign irq_o = lines_q.irq;
    assign fiq_o = lines_q.fiq;
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
    import intc_route_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic [NSRC-1:0]  raw_i,
    input  logic [NSRC-1:0]  irq_stat_i,
    input  logic [NSRC-1:0]  fiq_stat_i,
    input  cfg_t             cfg_i,
    output logic [NSRC-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (idx_i)
            IX_IRQ_ST: rdata_o = irq_stat_i;
            IX_FIQ_ST: rdata_o = fiq_stat_i;
            IX_RAW:    rdata_o = raw_i;
            IX_ROUTE:  rdata_o = cfg_i.route;
            IX_EN_SET: rdata_o = cfg_i.en;
            IX_PROT:   rdata_o = {{(NSRC-1){1'b0}}, cfg_i.prot};
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic             bus_priv,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);
    cfg_t            cfg_w;
    logic [NSRC-1:0] irq_stat_w;
    logic [NSRC-1:0] fiq_stat_w;

    intc_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_priv  (bus_priv),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .cfg_o     (cfg_w)
    );

    intc_steer u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .en_i       (cfg_w.en),
        .route_i    (cfg_w.route),
        .irq_stat_o (irq_stat_w),
        .fiq_stat_o (fiq_stat_w),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    intc_rdmux u_rd (
        .idx_i      (bus_idx),
        .raw_i      (src_i),
        .irq_stat_i (irq_stat_w),
        .fiq_stat_i (fiq_stat_w),
        .cfg_i      (cfg_w),
        .rdata_o    (bus_rdata)
    );
endmodule

// File: rtl/intc_route_chk.sv
module intc_route_chk
    import intc_route_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_i,
    input logic             bus_en,
    input logic             bus_we,
    input logic             bus_priv,
    input logic [IDX_W-1:0] bus_idx,
    input logic [NSRC-1:0]  bus_wdata,
    input logic [NSRC-1:0]  bus_rdata,
    input logic             irq_o,
    input logic             fiq_o,
    input cfg_t             cfg_w
);
    logic wr_allowed;
    assign wr_allowed = bus_en && bus_we && (bus_priv || !cfg_w.prot);

    // R3: set port raises every written one
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allowed && bus_idx == IX_EN_SET) |=>
        ((cfg_w.en & $past(bus_wdata)) == $past(bus_wdata)));

    // R4: clear port drops every written one
    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allowed && bus_idx == IX_EN_CLR) |=>
        ((cfg_w.en & $past(bus_wdata)) == '0));

    // R8: protected non-privileged write freezes all registers
    a_r8_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !bus_priv && cfg_w.prot) |=>
        ($stable(cfg_w.en) && $stable(cfg_w.route) && $stable(cfg_w.prot)));

    // R5: masked status views
    a_r5_irq_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IX_IRQ_ST) |-> (bus_rdata == (src_i & cfg_w.en & ~cfg_w.route)));
    a_r5_fiq_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IX_FIQ_ST) |-> (bus_rdata == (src_i & cfg_w.en & cfg_w.route)));

    // R7: output lines follow the OR of their view one edge later
    a_r7_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(src_i & cfg_w.en & ~cfg_w.route))));
    a_r7_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(src_i & cfg_w.en & cfg_w.route))));

    // R4: clear port always reads zero
    a_r4_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IX_EN_CLR) |-> (bus_rdata == '0));
endmodule

bind intc_route intc_route_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_priv  (bus_priv),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .cfg_w     (cfg_w)
);

// File: tb/tb_intc_route.sv
module tb_intc_route;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_priv = 1'b1;
    logic [3:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_route dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_en(bus_en), .bus_we(bus_we), .bus_priv(bus_priv),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] data, input logic priv);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_priv = priv;
        bus_idx = idx; bus_wdata = data;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_priv = 1'b1; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] data);
        bus_idx = idx;
        #1;
        data = bus_rdata;
    endtask

    // settle: one more edge so the output registers see the new state
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd4, v); check("R1 enable reset", v, 32'h0);
        rd(4'd3, v); check("R1 route reset", v, 32'h0);
        rd(4'd8, v); check("R1 protect reset", v, 32'h0);
        check("R1 irq_o reset", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o reset", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] v;
        src_i = 32'hA5A5_0F0F;
        rd(4'd2, v); check("R2 raw view", v, 32'hA5A5_0F0F);
        rd(4'd0, v); check("R5 irq view masked off", v, 32'h0);
        settle();
        check("R7 no line while disabled", {30'b0, irq_o, fiq_o}, 32'h0);
        src_i = '0;
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(4'd4, 32'h0000_00F0, 1'b1);
        rd(4'd4, v); check("R3 set first", v, 32'h0000_00F0);
        wr(4'd4, 32'h0000_0003, 1'b1);
        rd(4'd4, v); check("R3 zeros keep bits", v, 32'h0000_00F3);
        wr(4'd5, 32'h0000_0030, 1'b1);
        rd(4'd4, v); check("R4 clear some", v, 32'h0000_00C3);
        rd(4'd5, v); check("R4 clear port reads zero", v, 32'h0);
        wr(4'd5, 32'hFFFF_FFFF, 1'b1);
        rd(4'd4, v); check("R4 clear all", v, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(4'd4, 32'h8000_0101, 1'b1);
        wr(4'd3, 32'h8000_0100, 1'b1);
        rd(4'd3, v); check("R6 route readback", v, 32'h8000_0100);
        src_i = 32'h0000_0001;
        rd(4'd0, v); check("R5 irq view bit0", v, 32'h0000_0001);
        rd(4'd1, v); check("R5 fiq view empty", v, 32'h0);
        settle();
        check("R7 irq line up", {31'b0, irq_o}, 32'h1);
        check("R6 fiq line idle", {31'b0, fiq_o}, 32'h0);
        src_i = 32'h8000_0100;
        rd(4'd1, v); check("R5 fiq view", v, 32'h8000_0100);
        rd(4'd0, v); check("R5 irq view after switch", v, 32'h0);
        settle();
        check("R7 fiq line up", {31'b0, fiq_o}, 32'h1);
        check("R7 irq line down", {31'b0, irq_o}, 32'h0);
        src_i = 32'h0000_0000;
        rd(4'd1, v); check("R9 fiq view drops at once", v, 32'h0);
        settle();
        check("R9 fiq line drops", {31'b0, fiq_o}, 32'h0);
        src_i = 32'h8000_0100;
        settle();
        check("R9 reassert again", {31'b0, fiq_o}, 32'h1);
        src_i = '0;
        settle();
    endtask

    task automatic t_protect();
        logic [31:0] v;
        wr(4'd8, 32'h1, 1'b0);
        rd(4'd8, v); check("R8 protect set", v, 32'h1);
        wr(4'd4, 32'h0000_F000, 1'b0);
        rd(4'd4, v); check("R8 set blocked", v, 32'h8000_0101);
        wr(4'd5, 32'hFFFF_FFFF, 1'b0);
        rd(4'd4, v); check("R8 clear blocked", v, 32'h8000_0101);
        wr(4'd3, 32'h0, 1'b0);
        rd(4'd3, v); check("R8 route blocked", v, 32'h8000_0100);
        wr(4'd8, 32'h0, 1'b0);
        rd(4'd8, v); check("R8 unprotect blocked", v, 32'h1);
        wr(4'd4, 32'h0000_F000, 1'b1);
        rd(4'd4, v); check("R8 privileged write", v, 32'h8000_F101);
        wr(4'd8, 32'h0, 1'b1);
        rd(4'd8, v); check("R8 privileged unprotect", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(4'd6, 32'hFFFF_FFFF, 1'b1);
        wr(4'd7, 32'hFFFF_FFFF, 1'b1);
        wr(4'd9, 32'hFFFF_FFFF, 1'b1);
        wr(4'd15, 32'hFFFF_FFFF, 1'b1);
        rd(4'd4, v); check("R10 enable untouched", v, 32'h8000_F101);
        rd(4'd3, v); check("R10 route untouched", v, 32'h8000_0100);
        rd(4'd8, v); check("R10 protect untouched", v, 32'h0);
        src_i = 32'hFFFF_FFFF;
        rd(4'd6, v);  check("R10 read idx6", v, 32'h0);
        rd(4'd12, v); check("R10 read idx12", v, 32'h0);
        src_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw();
        t_set_clear();
        t_route();
        t_protect();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule